// File: doc/BRIEF.md
# Firmware Image Pre-Load Validator

This block inspects a firmware image in a byte-addressed store before any part of it is copied into target memory. After a `start` pulse it streams the image body through a CRC-16 engine and compares the result with the checksum stored at the tail. It then follows a two-level pointer to a section header, from which it takes the offset and size of an instruction section and of a data section. Each offset and size is checked for alignment and for range, and the block confirms that a version string is present inside the data section.

The block reads the store through a simple port: `rd_en` and `rd_addr` in one cycle, and the byte on `rd_data` in the next. When checking ends, `done` rises and stays high together with `valid` and a result code until the next accepted `start`. When the image passes every check, the absolute section offsets and sizes are on the output ports, ready for a loader.

Top module: `fimg_check`

## Requirements
- R1: The checksum is CRC-16 with polynomial 0x1021, initial value 0, shifted MSB first, over bytes 0 to size-3. It is stored big-endian: the high byte is at size-2 and the low byte at size-1. A mismatch, or an image shorter than 2 bytes, gives code 1.
- R2: The primary offset is the little-endian 16-bit value at byte `PRIM_LOC`, shifted left by `PRIM_SHIFT`. If those two bytes are not inside the image, the code is 2.
- R3: The section header starts at primary offset + `HDR_DISP` and spans 16 bytes: 4 unused bytes, then four 3-byte little-endian fields in the order instruction offset, instruction size, data offset, data size. If the whole header is not inside the image, the code is 2.
- R4: On success, `instr_off` and `data_off` equal the primary offset plus the respective header field, and `instr_size` and `data_size` equal the header fields.
- R5: A section size that is not a multiple of 4 gives code 3.
- R6: A section whose absolute offset plus size exceeds the image size gives code 4. A section that ends exactly at the image end is accepted.
- R7: The version string is `VER_LEN` bytes at absolute data offset + `VER_DISP`. It must lie inside the image and its first byte must be nonzero, otherwise the code is 5.
- R8: The checks run in this order, and only the first failure is reported: CRC, primary field, header, instruction alignment, instruction range, data alignment, data range, version.
- R9: `done`, `valid` and `err_code` hold until the next `start`. A `start` that arrives while a check is running is ignored. `valid` is 1 exactly when the code is 0.
- R10: No read is issued at an address equal to or beyond the image size that was latched at `start`.
- R11: After reset, `done`, `valid`, `err_code` and `rd_en` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a check; accepted only when idle |
| img_size | input | AW | Image length in bytes, latched at start |
| rd_en | output | 1 | Byte read request |
| rd_addr | output | AW | Byte address of the read |
| rd_data | input | 8 | Read byte, one cycle after the request |
| done | output | 1 | Checking finished; held until the next start |
| valid | output | 1 | Image passed every check |
| err_code | output | 3 | 0 ok, 1 CRC, 2 header, 3 alignment, 4 range, 5 version |
| instr_off | output | AW | Absolute instruction section offset |
| instr_size | output | 24 | Instruction section size |
| data_off | output | AW | Absolute data section offset |
| data_size | output | 24 | Data section size |

## Verification
The bench builds the block with a shift of 4, a header displacement of 0x20, a version displacement of 0x10 and an 8-byte version string. With these values every pointer, section and version string fits inside a 160-byte image, so each error path and each exact-fit boundary costs only a few hundred cycles to reach. A nested sweep over primary field, instruction size, data offset, data size and version byte covers the exact end-of-image fits, the one-past fits, misalignment and an empty version byte. A separate sweep of image sizes from 0 to 14 covers the truncated-image cases.

// File: rtl/fimg_pkg.sv
package fimg_pkg;

    typedef enum logic [2:0] {
        FE_NONE    = 3'd0,
        FE_CRC     = 3'd1,
        FE_HDR     = 3'd2,
        FE_ALIGN   = 3'd3,
        FE_RANGE   = 3'd4,
        FE_VERSION = 3'd5
    } fimg_err_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_BODY,
        ST_TAIL,
        ST_PRIM,
        ST_FIELD,
        ST_JUDGE,
        ST_VER,
        ST_FIN
    } fimg_state_e;

    localparam logic [15:0] CRC_POLY = 16'h1021;
    localparam int FIELD_BYTES = 3;
    localparam int HDR_BYTES   = 16;
    localparam int HDR_PAD     = 4;

    function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r;
        r = c ^ {b, 8'h00};
        for (int i = 0; i < 8; i++) begin
            r = r[15] ? ((r << 1) ^ CRC_POLY) : (r << 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/fimg_crc16.sv
module fimg_crc16
    import fimg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        clr,
    input  logic        en,
    input  logic [7:0]  din,
    output logic [15:0] crc
);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            crc <= 16'h0000;
        end else if (en) begin
            crc <= crc16_step(crc, din);
        end
    end

    // R1: a clear always restarts the checksum from zero
    a_r1_clear_zero: assert property (@(posedge clk) disable iff (rst)
        clr |=> (crc == 16'h0000));

endmodule

// File: rtl/fimg_stream.sv
module fimg_stream #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] count,
    output logic          rd_en,
    output logic [AW-1:0] rd_addr,
    input  logic [7:0]    rd_data,
    output logic          byte_vld,
    output logic [7:0]    byte_out,
    output logic [23:0]   value,
    output logic          done
);

    localparam int VB = 24 / 8;

    logic          busy;
    logic          pend;
    logic [AW-1:0] addr;
    logic [AW-1:0] left;
    logic [1:0]    idx;

    assign rd_en    = busy && (left != '0);
    assign rd_addr  = addr;
    assign done     = busy && (left == '0) && !pend;
    assign byte_vld = pend;
    assign byte_out = rd_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            pend  <= 1'b0;
            addr  <= '0;
            left  <= '0;
            idx   <= '0;
            value <= '0;
        end else begin
            pend <= rd_en;
            if (go) begin
                busy  <= 1'b1;
                addr  <= base;
                left  <= count;
                idx   <= '0;
                value <= '0;
            end else begin
                if (rd_en) begin
                    addr <= addr + 1'b1;
                    left <= left - 1'b1;
                end
                if (pend && (int'(idx) < VB)) begin
                    value[idx*8 +: 8] <= rd_data;
                    idx <= idx + 1'b1;
                end
                if (done) begin
                    busy <= 1'b0;
                end
            end
        end
    end

    // R9: the controller only launches a fetch when the streamer is idle
    a_r9_go_when_idle: assert property (@(posedge clk) disable iff (rst)
        go |-> !busy);

    // R10: a returned byte always belongs to a request of the previous cycle
    a_r10_data_after_req: assert property (@(posedge clk) disable iff (rst)
        byte_vld |-> $past(rd_en));

endmodule

// File: rtl/fimg_check.sv
module fimg_check
    import fimg_pkg::*;
#(
    parameter int          AW         = 32,
    parameter int          PRIM_LOC   = 8,
    parameter int          PRIM_SHIFT = 12,
    parameter int          HDR_DISP   = 'h300,
    parameter int          VER_DISP   = 'h200,
    parameter int          VER_LEN    = 64
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [AW-1:0] img_size,
    output logic          rd_en,
    output logic [AW-1:0] rd_addr,
    input  logic [7:0]    rd_data,
    output logic          done,
    output logic          valid,
    output logic [2:0]    err_code,
    output logic [AW-1:0] instr_off,
    output logic [23:0]   instr_size,
    output logic [AW-1:0] data_off,
    output logic [23:0]   data_size
);

    localparam int XW = AW + 2;

    function automatic logic fits(input logic [XW-1:0] off, input logic [XW-1:0] len,
                                  input logic [AW-1:0] sz);
        return (off + len) <= XW'(sz);
    endfunction

    fimg_state_e   st;
    fimg_err_e     code_q;
    logic [AW-1:0] size_q;
    logic [XW-1:0] prim;
    logic [23:0]   fld [4];
    logic [1:0]    fidx;

    logic          s_go;
    logic [AW-1:0] s_base;
    logic [AW-1:0] s_cnt;
    logic          s_vld;
    logic [7:0]    s_byte;
    logic [23:0]   s_val;
    logic          s_done;

    logic          crc_clr;
    logic [15:0]   crc;

    logic [XW-1:0] i_abs;
    logic [XW-1:0] d_abs;
    logic [XW-1:0] v_abs;
    logic [XW-1:0] prim_new;
    logic [XW-1:0] hdr_at;

    assign i_abs    = prim + XW'(fld[0]);
    assign d_abs    = prim + XW'(fld[2]);
    assign v_abs    = d_abs + XW'(VER_DISP);
    assign prim_new = XW'(s_val[15:0]) << PRIM_SHIFT;
    assign hdr_at   = prim_new + XW'(HDR_DISP);

    assign instr_off  = i_abs[AW-1:0];
    assign data_off   = d_abs[AW-1:0];
    assign instr_size = fld[1];
    assign data_size  = fld[3];

    fimg_stream #(.AW(AW)) u_stream (
        .clk      (clk),
        .rst      (rst),
        .go       (s_go),
        .base     (s_base),
        .count    (s_cnt),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .byte_vld (s_vld),
        .byte_out (s_byte),
        .value    (s_val),
        .done     (s_done)
    );

    fimg_crc16 u_crc (
        .clk (clk),
        .rst (rst),
        .clr (crc_clr),
        .en  (s_vld && (st == ST_BODY)),
        .din (s_byte),
        .crc (crc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            code_q   <= FE_NONE;
            size_q   <= '0;
            prim     <= '0;
            fidx     <= '0;
            s_go     <= 1'b0;
            s_base   <= '0;
            s_cnt    <= '0;
            crc_clr  <= 1'b0;
            done     <= 1'b0;
            valid    <= 1'b0;
            err_code <= FE_NONE;
            for (int k = 0; k < 4; k++) fld[k] <= '0;
        end else begin
            s_go    <= 1'b0;
            crc_clr <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (start) begin
                        done     <= 1'b0;
                        valid    <= 1'b0;
                        err_code <= FE_NONE;
                        size_q   <= img_size;
                        prim     <= '0;
                        for (int k = 0; k < 4; k++) fld[k] <= '0;
                        if (img_size < AW'(2)) begin
                            code_q <= FE_CRC;
                            st     <= ST_FIN;
                        end else begin
                            crc_clr <= 1'b1;
                            s_go    <= 1'b1;
                            s_base  <= '0;
                            s_cnt   <= img_size - AW'(2);
                            st      <= ST_BODY;
                        end
                    end
                end
                ST_BODY: begin
                    if (s_done) begin
                        s_go   <= 1'b1;
                        s_base <= size_q - AW'(2);
                        s_cnt  <= AW'(2);
                        st     <= ST_TAIL;
                    end
                end
                ST_TAIL: begin
                    if (s_done) begin
                        if ({s_val[7:0], s_val[15:8]} != crc) begin
                            code_q <= FE_CRC;
                            st     <= ST_FIN;
                        end else if (!fits(XW'(PRIM_LOC), XW'(2), size_q)) begin
                            code_q <= FE_HDR;
                            st     <= ST_FIN;
                        end else begin
                            s_go   <= 1'b1;
                            s_base <= AW'(PRIM_LOC);
                            s_cnt  <= AW'(2);
                            st     <= ST_PRIM;
                        end
                    end
                end
                ST_PRIM: begin
                    if (s_done) begin
                        prim <= prim_new;
                        if (!fits(hdr_at, XW'(HDR_BYTES), size_q)) begin
                            code_q <= FE_HDR;
                            st     <= ST_FIN;
                        end else begin
                            fidx   <= '0;
                            s_go   <= 1'b1;
                            s_base <= AW'(hdr_at + XW'(HDR_PAD));
                            s_cnt  <= AW'(FIELD_BYTES);
                            st     <= ST_FIELD;
                        end
                    end
                end
                ST_FIELD: begin
                    if (s_done) begin
                        fld[fidx] <= s_val;
                        if (fidx == 2'd3) begin
                            st <= ST_JUDGE;
                        end else begin
                            fidx   <= fidx + 1'b1;
                            s_go   <= 1'b1;
                            s_base <= s_base + AW'(FIELD_BYTES);
                        end
                    end
                end
                ST_JUDGE: begin
                    st <= ST_FIN;
                    if (fld[1][1:0] != 2'b00) begin
                        code_q <= FE_ALIGN;
                    end else if (!fits(i_abs, XW'(fld[1]), size_q)) begin
                        code_q <= FE_RANGE;
                    end else if (fld[3][1:0] != 2'b00) begin
                        code_q <= FE_ALIGN;
                    end else if (!fits(d_abs, XW'(fld[3]), size_q)) begin
                        code_q <= FE_RANGE;
                    end else if (!fits(v_abs, XW'(VER_LEN), size_q)) begin
                        code_q <= FE_VERSION;
                    end else begin
                        s_go   <= 1'b1;
                        s_base <= AW'(v_abs);
                        s_cnt  <= AW'(1);
                        st     <= ST_VER;
                    end
                end
                ST_VER: begin
                    if (s_done) begin
                        code_q <= (s_val[7:0] == 8'h00) ? FE_VERSION : FE_NONE;
                        st     <= ST_FIN;
                    end
                end
                ST_FIN: begin
                    done     <= 1'b1;
                    valid    <= (code_q == FE_NONE);
                    err_code <= code_q;
                    st       <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R10: every byte request stays inside the image latched at start
    a_r10_read_inside: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> (rd_addr < size_q));

    // R9: results hold while no new start arrives
    a_r9_result_hold: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> (done && $stable(err_code) && $stable(valid)));

    // R9: a passing result always carries code zero
    a_r9_valid_means_ok: assert property (@(posedge clk) disable iff (rst)
        valid |-> (done && (err_code == FE_NONE)));

    // R11: no read activity while a result is being presented
    a_r11_quiet_when_done: assert property (@(posedge clk) disable iff (rst)
        done |-> !rd_en);

endmodule

// File: tb/sim_fimg_check.sv
module sim_fimg_check;

    localparam int AW  = 32;
    localparam int SZ  = 160;
    localparam int SH  = 4;
    localparam int HD  = 'h20;
    localparam int VD  = 'h10;
    localparam int VL  = 8;
    localparam int PL  = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [AW-1:0] img_size = '0;
    logic          rd_en;
    logic [AW-1:0] rd_addr;
    logic [7:0]    rd_data = '0;
    logic          done, valid;
    logic [2:0]    err_code;
    logic [AW-1:0] instr_off, data_off;
    logic [23:0]   instr_size, data_size;

    int checks = 0;
    int fails  = 0;
    int oob    = 0;
    int cur_sz = 0;
    longint cycles = 0;
    logic [7:0] mem [256];

    always #4 clk = ~clk;

    fimg_check #(.AW(AW), .PRIM_LOC(PL), .PRIM_SHIFT(SH), .HDR_DISP(HD),
                 .VER_DISP(VD), .VER_LEN(VL)) u0 (
        .clk(clk), .rst(rst), .start(start), .img_size(img_size),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .done(done), .valid(valid), .err_code(err_code),
        .instr_off(instr_off), .instr_size(instr_size),
        .data_off(data_off), .data_size(data_size));

    always @(posedge clk) begin
        if (rd_en) begin
            if (rd_addr >= AW'(cur_sz)) oob++;
            rd_data <= mem[rd_addr[7:0]];
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            fails++;
            $display("FAIL watchdog: run hung, actual cycles %0d expected below 190000", cycles);
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] crc_model(input int n);
        logic [15:0] c = 16'h0000;
        for (int i = 0; i < n; i++) begin
            for (int b = 7; b >= 0; b--) begin
                logic fb = c[15] ^ mem[i][b];
                c = {c[14:0], 1'b0};
                if (fb) c = c ^ 16'h1021;
            end
        end
        return c;
    endfunction

    task automatic build(input int p, input int isz, input int doff, input int dsz,
                         input int vb, input int sz, input bit bad);
        int h;
        logic [15:0] c;
        for (int i = 0; i < 256; i++) mem[i] = 8'((i * 7 + 3) & 8'hff);
        mem[PL] = 8'(p); mem[PL+1] = 8'(p >> 8);
        h = (p << SH) + HD + 4;
        mem[h]   = 8'(8);     mem[h+1]  = 0; mem[h+2]  = 0;
        mem[h+3] = 8'(isz);   mem[h+4]  = 8'(isz >> 8);  mem[h+5]  = 8'(isz >> 16);
        mem[h+6] = 8'(doff);  mem[h+7]  = 8'(doff >> 8); mem[h+8]  = 8'(doff >> 16);
        mem[h+9] = 8'(dsz);   mem[h+10] = 8'(dsz >> 8);  mem[h+11] = 8'(dsz >> 16);
        mem[((p << SH) + doff + VD) & 255] = 8'(vb);
        if (sz >= 2) begin
            c = crc_model(sz - 2);
            mem[sz-2] = c[15:8];
            mem[sz-1] = c[7:0];
        end
        if (bad) mem[3] = mem[3] ^ 8'h10;
    endtask

    function automatic longint le3(input int a);
        return longint'(mem[a]) | (longint'(mem[a+1]) << 8) | (longint'(mem[a+2]) << 16);
    endfunction

    task automatic model(input int sz, output int code, output longint io, output longint is,
                         output longint dof, output longint ds);
        longint prim, h, f0, f2;
        code = 0; io = 0; is = 0; dof = 0; ds = 0;
        if (sz < 2) code = 1;
        else if (crc_model(sz - 2) != {mem[sz-2], mem[sz-1]}) code = 1;
        if (code == 0) begin
            if (PL + 2 > sz) code = 2;
            else begin
                prim = (longint'(mem[PL]) | (longint'(mem[PL+1]) << 8)) << SH;
                h = prim + HD;
                if (h + 16 > sz) code = 2;
                else begin
                    f0 = le3(int'(h) + 4); is = le3(int'(h) + 7);
                    f2 = le3(int'(h) + 10); ds = le3(int'(h) + 13);
                    io = prim + f0; dof = prim + f2;
                    if (is % 4 != 0) code = 3;
                    else if (io + is > sz) code = 4;
                    else if (ds % 4 != 0) code = 3;
                    else if (dof + ds > sz) code = 4;
                    else if (dof + VD + VL > sz) code = 5;
                    else if (mem[int'(dof) + VD] == 0) code = 5;
                end
            end
        end
    endtask

    task automatic launch(input int sz);
        int w = 0;
        @(negedge clk);
        img_size = AW'(sz); cur_sz = sz; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done && w < 5000) begin @(negedge clk); w++; end
        check("R9 done reached", longint'(done), 1);
    endtask

    task automatic run_and_check(input int sz);
        int code;
        longint io, is, dof, ds;
        model(sz, code, io, is, dof, ds);
        oob = 0;
        launch(sz);
        // R1 R2 R3 R5 R6 R7 R8: first failing check decides the code
        check("R8 result code", longint'(err_code), code);
        check("R9 valid flag", longint'(valid), (code == 0) ? 1 : 0);
        check("R10 reads inside image", oob, 0);
        if (code == 0) begin
            check("R4 instr offset", longint'(instr_off), io);
            check("R4 instr size", longint'(instr_size), is);
            check("R4 data offset", longint'(data_off), dof);
            check("R4 data size", longint'(data_size), ds);
        end
    endtask

    initial begin
        int isz_l [5];
        int code;
        longint io, is, dof, ds;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11: reset state
        check("R11 done after reset", longint'(done), 0);
        check("R11 valid after reset", longint'(valid), 0);
        check("R11 code after reset", longint'(err_code), 0);
        check("R11 rd_en after reset", longint'(rd_en), 0);

        // R1 R2 R3: truncated images
        for (int sz = 0; sz <= 14; sz++) begin
            build(0, 4, 0, 4, 8'h5a, sz, 1'b0);
            run_and_check(sz);
        end

        // R1: corrupted body
        for (int p = 0; p < 3; p++) begin
            build(p, 4, 0, 4, 8'h5a, SZ, 1'b1);
            run_and_check(SZ);
            check("R1 bad crc code", longint'(err_code), 1);
        end

        // R4 R5 R6 R7 R8: nested sweep
        for (int p = 0; p < 3; p++) begin
            isz_l = '{0, 4, 5, 12, SZ - 16};
            for (int a = 0; a < 5; a++) begin
                for (int d = 0; d < 4; d++) begin
                    int doff;
                    doff = (d == 0) ? 0 : (d == 1) ? 100 :
                           (d == 2) ? (SZ - VD - VL - (p << SH)) : (SZ - VD - VL + 1 - (p << SH));
                    for (int z = 0; z < 4; z++) begin
                        int dabs, dsz;
                        dabs = (p << SH) + doff;
                        dsz = (z == 0) ? 4 : (z == 1) ? 6 :
                              (z == 2) ? ((SZ - dabs) & ~3) : (((SZ - dabs) & ~3) + 4);
                        for (int v = 0; v < 2; v++) begin
                            build(p, isz_l[a], doff, dsz, (v == 0) ? 0 : 8'h5a, SZ, 1'b0);
                            run_and_check(SZ);
                        end
                    end
                end
            end
        end

        // R9: results hold, and a start during a run is ignored
        build(1, 8, 20, 8, 8'h41, SZ, 1'b0);
        model(SZ, code, io, is, dof, ds);
        @(negedge clk);
        img_size = AW'(SZ); cur_sz = SZ; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (30) @(negedge clk);
        img_size = AW'(1); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int w = 0; w < 5000 && !done; w++) @(negedge clk);
        check("R9 start while busy ignored", longint'(err_code), code);
        check("R9 valid after ignored start", longint'(valid), 1);
        repeat (5) @(negedge clk);
        check("R9 done held", longint'(done), 1);
        check("R9 code held", longint'(err_code), code);

        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule